// File: doc/BRIEF.md
# Boot-Swappable Chip-Select Address Decoder

This block sits between a host request port and the memory controllers. Each request arrives as a byte address, an access size and a flag that marks the display-controller host. The block turns each request into one-hot region selects:

- four external static-memory chip selects;
- one external SDRAM select;
- one internal SRAM select.

It also reports alignment errors, access-size errors and addresses that fall outside every region. All results come out of registers, one clock after the request strobe.

A boot-mode pin is sampled while reset is held. If it was high when reset was released, chip select 0 answers the window normally owned by chip select 3, and the other way round. This lets the system boot from the device wired to chip select 3. The latched value is held for the rest of operation and is shown on a status output, so the pin may be reused for other functions after reset.

Top module: `csel_decode_top`

## Requirements
- R1: With the boot status low, chip selects 0, 1, 2 and 3 own the 32 MB windows at 0x0000_0000, 0x0200_0000, 0x0400_0000 and 0x0600_0000. Bit k of `cs_sel` is chip select k.
- R2: `sdram_sel` covers the 64 MB window at 0x1000_0000, and `sram_sel` covers the 512 KB window at 0x2000_0000.
- R3: The boot pin is captured on every clock edge while `rst_n` is low. If the captured value is 1, the windows of chip selects 0 and 3 are exchanged. Chip selects 1 and 2 and the other regions are unchanged.
- R4: While `rst_n` is high, `boot_status` holds the captured boot value, and changes on `boot_pin` have no effect on it or on the decode.
- R5: `req_size` encodes 00 = byte, 01 = halfword and 10 = word. Code 11 raises `size_err`.
- R6: A halfword with address bit 0 set, or a word with either of address bits 1:0 set, raises `align_err`. Bytes are never misaligned, and code 11 never raises `align_err`.
- R7: When `req_disp` is 1, any size code other than 01 raises `size_err`.
- R8: An address inside no window raises `decode_miss`, and every select is low.
- R9: At most one select output is high in a cycle. No select is high while `align_err` or `size_err` is high.
- R10: Outputs are registered. A request strobed at one rising edge shows its result after that edge. If `req_valid` is low at an edge, all selects and flags are low after it. While `rst_n` is low (synchronous), all selects and flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; boot pin sampled while low |
| boot_pin | input | 1 | Boot-mode pin, meaningful only during reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Byte address |
| req_size | input | 2 | Access size code |
| req_disp | input | 1 | Request comes from the display-controller host |
| cs_sel | output | 4 | One-hot external chip selects |
| sdram_sel | output | 1 | SDRAM region select |
| sram_sel | output | 1 | Internal SRAM region select |
| align_err | output | 1 | Misaligned access |
| size_err | output | 1 | Illegal size, or a non-halfword size from the display host |
| decode_miss | output | 1 | Address outside all regions |
| boot_status | output | 1 | Latched boot-mode value |

## Verification
The bench sweeps every region's first word, last word and first byte past its end, combined with all four low address offsets, all size codes and both host types. It runs this sweep once under each boot mode.

- A decoder with an off-by-one window bound would select at the byte just past a region, or miss its last word.
- A swap applied to the wrong pair, or not applied at all, shows up as the wrong chip-select bit at the bases of windows 0 and 3.
- The boot pin is toggled after reset. A latch that keeps tracking the pin would flip `boot_status` and the decode.
- An alignment or size check that ignores the host flag or the illegal code would leave a select high beside an error flag, or drop the flag.

// File: rtl/csel_pkg.sv
package csel_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_BAD  = 2'b11
    } acc_size_e;

    localparam int NUM_CS = 4;

    typedef struct packed {
        logic [NUM_CS-1:0] cs;
        logic              sdram;
        logic              sram;
        logic              align_err;
        logic              size_err;
        logic              miss;
    } dec_out_t;

endpackage

// File: rtl/csel_boot_latch.sv
module csel_boot_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic swap_q
);
    logic swap_d;

    always_comb begin
        swap_d = swap_q;
        if (!rst_n) swap_d = pin;
    end

    always_ff @(posedge clk) begin
        swap_q <= swap_d;
    end

    p_boot_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(swap_q))
        else $error("boot latch changed after reset");
endmodule

// File: rtl/csel_window.sv
module csel_window #(
    parameter int          ADDR_W = 32,
    parameter int          LG2    = 25,
    parameter logic [31:0] BASE   = 32'h0
) (
    input  logic [ADDR_W-1-LG2:0] addr_hi,
    output logic                  hit
);
    localparam logic [ADDR_W-1-LG2:0] TAG = BASE[ADDR_W-1:LG2];

    always_comb begin
        hit = (addr_hi == TAG);
    end
endmodule

// File: rtl/csel_size_check.sv
module csel_size_check
    import csel_pkg::*;
(
    input  logic [1:0] addr_lo,
    input  logic [1:0] size,
    input  logic       disp,
    output logic       align_err,
    output logic       size_err
);
    acc_size_e sz;

    always_comb begin
        sz        = acc_size_e'(size);
        align_err = 1'b0;
        size_err  = 1'b0;
        unique case (sz)
            SZ_BYTE: align_err = 1'b0;
            SZ_HALF: align_err = addr_lo[0];
            SZ_WORD: align_err = |addr_lo;
            SZ_BAD:  size_err  = 1'b1;
        endcase
        if (disp && sz != SZ_HALF) size_err = 1'b1;
    end

    always_comb begin
        if (sz == SZ_BYTE) p_byte_never_misaligned_r6: assert (!align_err);
    end
endmodule

// File: rtl/csel_decode_top.sv
module csel_decode_top
    import csel_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          CS_LG2     = 25,
    parameter logic [31:0] CS_BASE    = 32'h0000_0000,
    parameter int          SDRAM_LG2  = 26,
    parameter logic [31:0] SDRAM_BASE = 32'h1000_0000,
    parameter int          SRAM_LG2   = 19,
    parameter logic [31:0] SRAM_BASE  = 32'h2000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_pin,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_disp,
    output logic [NUM_CS-1:0] cs_sel,
    output logic              sdram_sel,
    output logic              sram_sel,
    output logic              align_err,
    output logic              size_err,
    output logic              decode_miss,
    output logic              boot_status
);
    localparam int LAST_CS = NUM_CS - 1;

    logic              swap_q;
    logic [NUM_CS-1:0] win_hit;
    logic              sdram_hit;
    logic              sram_hit;
    logic              chk_align;
    logic              chk_size;
    logic              unused_addr_bits;
    dec_out_t          out_d;
    dec_out_t          out_q;

    assign unused_addr_bits = ^req_addr[SRAM_LG2-1:2];

    csel_boot_latch u_boot (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin    (boot_pin),
        .swap_q (swap_q)
    );

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs_win
        localparam logic [31:0] WBASE = CS_BASE + (32'(i) << CS_LG2);
        csel_window #(.ADDR_W(ADDR_W), .LG2(CS_LG2), .BASE(WBASE)) u_win (
            .addr_hi (req_addr[ADDR_W-1:CS_LG2]),
            .hit     (win_hit[i])
        );
    end

    csel_window #(.ADDR_W(ADDR_W), .LG2(SDRAM_LG2), .BASE(SDRAM_BASE)) u_sdram_win (
        .addr_hi (req_addr[ADDR_W-1:SDRAM_LG2]),
        .hit     (sdram_hit)
    );

    csel_window #(.ADDR_W(ADDR_W), .LG2(SRAM_LG2), .BASE(SRAM_BASE)) u_sram_win (
        .addr_hi (req_addr[ADDR_W-1:SRAM_LG2]),
        .hit     (sram_hit)
    );

    csel_size_check u_chk (
        .addr_lo   (req_addr[1:0]),
        .size      (req_size),
        .disp      (req_disp),
        .align_err (chk_align),
        .size_err  (chk_size)
    );

    always_comb begin
        logic [NUM_CS-1:0] cs_map;
        logic              any_hit;
        logic              blocked;
        cs_map = win_hit;
        if (swap_q) begin
            cs_map[0]       = win_hit[LAST_CS];
            cs_map[LAST_CS] = win_hit[0];
        end
        any_hit = (|win_hit) | sdram_hit | sram_hit;
        blocked = chk_align | chk_size | ~any_hit;

        out_d = '0;
        if (req_valid) begin
            out_d.align_err = chk_align;
            out_d.size_err  = chk_size;
            out_d.miss      = ~any_hit;
            if (!blocked) begin
                out_d.cs    = cs_map;
                out_d.sdram = sdram_hit;
                out_d.sram  = sram_hit;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign cs_sel      = out_q.cs;
    assign sdram_sel   = out_q.sdram;
    assign sram_sel    = out_q.sram;
    assign align_err   = out_q.align_err;
    assign size_err    = out_q.size_err;
    assign decode_miss = out_q.miss;
    assign boot_status = swap_q;

    p_sel_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cs_sel, sdram_sel, sram_sel}))
        else $error("more than one select");

    p_err_blocks_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (align_err || size_err) |-> ({cs_sel, sdram_sel, sram_sel} == '0))
        else $error("select with error");

    p_miss_no_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        decode_miss |-> ({cs_sel, sdram_sel, sram_sel} == '0))
        else $error("select on miss");

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ({cs_sel, sdram_sel, sram_sel, align_err, size_err, decode_miss} == '0))
        else $error("output without request");
endmodule

// File: tb/sim_csel_decode_top.sv
module sim_csel_decode_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_pin = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_disp = 1'b0;
    logic [3:0]  cs_sel;
    logic        sdram_sel, sram_sel, align_err, size_err, decode_miss, boot_status;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    csel_decode_top u0 (
        .clk(clk), .rst_n(rst_n), .boot_pin(boot_pin), .req_valid(req_valid),
        .req_addr(req_addr), .req_size(req_size), .req_disp(req_disp),
        .cs_sel(cs_sel), .sdram_sel(sdram_sel), .sram_sel(sram_sel),
        .align_err(align_err), .size_err(size_err), .decode_miss(decode_miss),
        .boot_status(boot_status)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h (addr=%h size=%0d disp=%0d)",
                     tag, act, exp, req_addr, req_size, req_disp);
        end
    endtask

    function automatic logic [5:0] exp_sel(logic [31:0] a, logic boot);
        logic [5:0] s;
        int idx;
        s = '0;
        if ((a >> 25) < 4) begin
            idx = int'(a >> 25);
            if (boot && (idx == 0 || idx == 3)) idx = 3 - idx;
            s[2 + idx] = 1'b1;
        end else if ((a >> 26) == 4) s[1] = 1'b1;
        else if ((a >> 19) == 32'h400) s[0] = 1'b1;
        return s;
    endfunction

    task automatic do_reset(logic b);
        @(negedge clk);
        rst_n = 1'b0; boot_pin = b; req_valid = 1'b1; req_addr = 32'h0; req_size = 2'b10;
        repeat (3) @(negedge clk);
        check("R10 reset outputs", {26'b0, cs_sel, sdram_sel, sram_sel}, 32'h0);
        check("R10 reset flags", {29'b0, align_err, size_err, decode_miss}, 32'h0);
        rst_n = 1'b1;
        boot_pin = ~b;
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        check("R4 status holds", {31'b0, boot_status}, {31'b0, b});
        boot_pin = b;
        @(negedge clk);
        boot_pin = ~b;
        @(negedge clk);
        check("R4 status ignores pin", {31'b0, boot_status}, {31'b0, b});
    endtask

    task automatic apply(logic [31:0] a, logic [1:0] sz, logic dp, logic boot);
        logic [5:0] s;
        logic       miss, al, se;
        string      tag;
        s    = exp_sel(a, boot);
        miss = (s == 0);
        se   = (sz == 2'b11) || (dp && sz != 2'b01);
        al   = (sz == 2'b01 && a[0]) || (sz == 2'b10 && a[1:0] != 2'b00);
        if (al || se) s = '0;
        req_valid = 1'b1; req_addr = a; req_size = sz; req_disp = dp;
        @(negedge clk);
        if (boot && (a >> 25) < 4 && ((a >> 25) == 0 || (a >> 25) == 3)) tag = "R3 swapped select";
        else if (miss) tag = "R8 miss selects";
        else if (al || se) tag = "R9 select blocked";
        else if ((a >> 25) < 4) tag = "R1 chip select";
        else tag = "R2 region select";
        check(tag, {26'b0, cs_sel, sdram_sel, sram_sel}, {26'b0, s});
        check("R6 align flag", {31'b0, align_err}, {31'b0, al});
        check(dp ? "R7 display size flag" : "R5 size flag", {31'b0, size_err}, {31'b0, se});
        check("R8 miss flag", {31'b0, decode_miss}, {31'b0, miss});
        check("R9 onehot", {31'b0, ($countones({cs_sel, sdram_sel, sram_sel}) <= 1)}, 32'h1);
        req_valid = 1'b0;
        @(negedge clk);
        check("R10 idle clears", {26'b0, cs_sel, sdram_sel, sram_sel, align_err, size_err, decode_miss} , 32'h0);
    endtask

    task automatic sweep(logic boot);
        logic [31:0] bases [6];
        logic [31:0] sizes [6];
        bases = '{32'h0000_0000, 32'h0200_0000, 32'h0400_0000, 32'h0600_0000,
                  32'h1000_0000, 32'h2000_0000};
        sizes = '{32'h0200_0000, 32'h0200_0000, 32'h0200_0000, 32'h0200_0000,
                  32'h0400_0000, 32'h0008_0000};
        for (int r = 0; r < 7; r++) begin
            for (int p = 0; p < 3; p++) begin
                logic [31:0] a;
                if (r == 6) a = (p == 0) ? 32'hFFFF_FFFC : (p == 1) ? 32'h0FFF_FFFC : 32'h1FFF_FFFC;
                else a = (p == 0) ? bases[r] : (p == 1) ? bases[r] + sizes[r] - 4 : bases[r] + sizes[r];
                for (int off = 0; off < 4; off++)
                    for (int sz = 0; sz < 4; sz++)
                        for (int dp = 0; dp < 2; dp++)
                            apply(a | 32'(off), 2'(sz), 1'(dp), boot);
            end
        end
    endtask

    initial begin
        do_reset(1'b0);
        sweep(1'b0);
        do_reset(1'b1);
        sweep(1'b1);
        check("R4 status final", {31'b0, boot_status}, 32'h1);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule